// File: doc/BRIEF.md
# GPIO interrupt detector

This block watches eight already-synchronized input lines and turns selected conditions on them into interrupt requests. Each line is configured on its own: it can react to a level or to a transition; in transition mode it reacts to one chosen edge or to both edges; and a polarity bit picks which edge or which level counts. Edge events are held in a sticky status bit until software clears them. Level status simply tracks the line.

A small register port sets the configuration and reads status. It has one address bus shared by reads and writes, a write strobe, write data and combinational read data. The port has no handshake and no back-pressure. Every write is taken at the clock edge where the strobe is high, and the read data always reflects the current address. The block drives eight per-line masked interrupt outputs and one combined request for an interrupt controller.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration bit, every enable bit and every raw status bit is 0 (edge mode, falling-edge polarity, no both-edge detection), all register reads return 0x00, and `irq_line` and `irq_any` are low.
- R2: Register 0 (`reg_addr` = 0) holds the per-line detection kind: bit value 0 selects edge detection and 1 selects level detection.
- R3: In edge mode with register 1 bit clear, register 2 selects the edge: 1 gives rising (sample 0 then 1) and 0 gives falling (sample 1 then 0). The raw bit sets at the clock edge where the new sample is first taken.
- R4: Setting a bit in register 1 makes that edge-mode line trigger on both rising and falling edges, whatever its register 2 bit holds.
- R5: In level mode, the raw bit equals the line when register 2 is 1 and the inverted line when it is 0. It follows the input in the same cycle, and a clear write has no lasting effect while the condition holds.
- R6: Edge raw bits are sticky. Writing register 6 clears each raw bit whose data bit is 1 and leaves the others untouched. Register 6 reads back 0x00.
- R7: If an edge on a line and a clear of that line fall on the same clock edge, the raw bit ends up set.
- R8: Register 4 reads raw status whatever the enables hold. Register 5 reads raw AND enable, where register 3 holds the read/write enable.
- R9: `irq_line[i]` equals masked status bit i, and `irq_any` is high exactly when any masked bit is set.
- R10: Registers 0 to 3 read back the last value written to them.
- R11: After the configuration is changed with the lines held stable, one write of 0xFF to register 6 leaves raw status at 0x00. It stays at 0x00 while the lines stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 8 | Synchronized line values |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_line | output | 8 | Per-line masked interrupt requests |
| irq_any | output | 1 | OR of all masked interrupt requests |

## Verification
The hardest case to reach from the ports is an edge and a clear of the same line landing on one clock edge. The bench reaches it by driving the new line value and the clear write from the same falling edge, so the detector and the clear logic both act at the next rising edge. Stale edge status left behind by a configuration change is the other hard case. The bench produces it by toggling the lines, then changing polarity and both-edge settings while the lines are held. It then clears and watches raw status stay at zero for several cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_SENSE  = 3'd0,
    RA_BOTH   = 3'd1,
    RA_POL    = 3'd2,
    RA_ENABLE = 3'd3,
    RA_RAW    = 3'd4,
    RA_MASKED = 3'd5,
    RA_CLEAR  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      sense,
  output logic [N-1:0]      both,
  output logic [N-1:0]      pol,
  output logic [N-1:0]      en,
  output logic [N-1:0]      clr_mask
);
  logic [N-1:0] sense_q, both_q, pol_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_SENSE:  sense_q <= wdata;
        RA_BOTH:   both_q  <= wdata;
        RA_POL:    pol_q   <= wdata;
        RA_ENABLE: en_q    <= wdata;
        default:   ;
      endcase
    end
  end

  // Clear is a one-cycle pulse, never stored.
  assign clr_mask = (wr_en && (addr == RA_CLEAR)) ? wdata : '0;
  assign sense    = sense_q;
  assign both     = both_q;
  assign pol      = pol_q;
  assign en       = en_q;
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] both,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr,
  output logic [N-1:0] edge_evt,
  output logic [N-1:0] edge_raw
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q;
    logic hold_q;
    logic rise, fall, evt;

    assign rise = line_in[i] & ~prev_q;
    assign fall = ~line_in[i] & prev_q;
    assign evt  = both[i] ? (rise | fall) : (pol[i] ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        prev_q <= line_in[i];
        // New event takes priority over a simultaneous clear.
        if (sense[i]) hold_q <= 1'b0;
        else          hold_q <= (hold_q & ~clr[i]) | evt;
      end
    end

    assign edge_evt[i] = evt;
    assign edge_raw[i] = hold_q;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] en,
  input  logic [N-1:0] edge_raw,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         any
);
  logic [N-1:0] level_hit;

  assign level_hit = ~(line_in ^ pol);
  assign raw       = (sense & level_hit) | (~sense & edge_raw);
  assign masked    = raw & en;
  assign any       = |masked;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic [N_LINES-1:0] irq_line,
  output logic               irq_any
);
  logic [N_LINES-1:0] cfg_sense, cfg_both, cfg_pol, cfg_en, clr_mask;
  logic [N_LINES-1:0] edge_evt, edge_raw, raw_st, masked_st;

  gpio_irq_cfg #(.N(N_LINES)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .sense    (cfg_sense),
    .both     (cfg_both),
    .pol      (cfg_pol),
    .en       (cfg_en),
    .clr_mask (clr_mask)
  );

  gpio_irq_edge #(.N(N_LINES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .sense    (cfg_sense),
    .both     (cfg_both),
    .pol      (cfg_pol),
    .clr      (clr_mask),
    .edge_evt (edge_evt),
    .edge_raw (edge_raw)
  );

  gpio_irq_status #(.N(N_LINES)) u_status (
    .line_in  (line_in),
    .sense    (cfg_sense),
    .pol      (cfg_pol),
    .en       (cfg_en),
    .edge_raw (edge_raw),
    .raw      (raw_st),
    .masked   (masked_st),
    .any      (irq_any)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_SENSE:  reg_rdata = cfg_sense;
      RA_BOTH:   reg_rdata = cfg_both;
      RA_POL:    reg_rdata = cfg_pol;
      RA_ENABLE: reg_rdata = cfg_en;
      RA_RAW:    reg_rdata = raw_st;
      RA_MASKED: reg_rdata = masked_st;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_line = masked_st;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] line_in,
  input logic [N-1:0] irq_line,
  input logic         irq_any,
  input logic [N-1:0] sense,
  input logic [N-1:0] raw,
  input logic [N-1:0] clr,
  input logic [N-1:0] edge_evt
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: nothing is requested on the first edge after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (!irq_any && (irq_line == '0)));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6: an edge status bit stays set unless cleared or mode changes
    a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense[i] && raw[i] && !clr[i]) |=> (raw[i] || sense[i]));

    // R7: an edge event always leaves the status set, even with a clear
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense[i] && edge_evt[i]) |=> (raw[i] || sense[i]));

    // R3: edge status only rises after the line sample changed
    a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && !sense[i] && $past(!sense[i]) && !$past(raw[i]) && raw[i])
      |-> ($past(line_in[i]) != $past(line_in[i], 2)));

    // R8: a per-line request never appears without raw status
    a_r8_masked_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line[i] |-> raw[i]);
  end
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N(N_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_in  (line_in),
  .irq_line (irq_line),
  .irq_any  (irq_any),
  .sense    (cfg_sense),
  .raw      (raw_st),
  .clr      (clr_mask),
  .edge_evt (edge_evt)
);

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_in = 8'h00;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, irq_line;
  logic       irq_any;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line), .irq_any(irq_any)
  );

  // sense, both, pol, enable, start, end, expected raw
  localparam logic [55:0] VEC [5] = '{
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F},
    {8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'hF0, 8'h0F},
    {8'h00, 8'hFF, 8'hAA, 8'hF0, 8'h33, 8'h55, 8'h66},
    {8'hF0, 8'h00, 8'hCC, 8'hFF, 8'h00, 8'hA5, 8'h94},
    {8'h00, 8'h0F, 8'hF0, 8'h33, 8'h5A, 8'hA5, 8'hAF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic put(input logic [7:0] v);
    @(negedge clk);
    line_in = v;
  endtask

  task automatic do_reset(input logic [7:0] lv);
    @(negedge clk);
    rst_n = 1'b0; line_in = lv;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    // R1: reset state
    do_reset(8'h00);
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], r);
      chk("R1 reg read after reset", r, 8'h00);
    end
    chk("R1 irq_line after reset", irq_line, 8'h00);
    chk("R1 irq_any after reset", {7'd0, irq_any}, 8'h00);

    // R10: readback
    wr(3'd0, 8'h5A); rd(3'd0, r); chk("R10 sense readback", r, 8'h5A);
    wr(3'd1, 8'hC3); rd(3'd1, r); chk("R10 both readback", r, 8'hC3);
    wr(3'd2, 8'h96); rd(3'd2, r); chk("R10 pol readback", r, 8'h96);
    wr(3'd3, 8'h3C); rd(3'd3, r); chk("R10 enable readback", r, 8'h3C);
    do_reset(8'h00);

    // Vector table: R2 R3 R4 R5 R8 R9
    for (int k = 0; k < 5; k++) begin
      logic [55:0] v;
      logic [7:0] ex, en;
      v  = VEC[k];
      en = v[31:24];
      ex = v[7:0];
      put(v[23:16]);
      wr(3'd0, v[55:48]);
      wr(3'd1, v[47:40]);
      wr(3'd2, v[39:32]);
      wr(3'd3, en);
      repeat (3) @(negedge clk);
      wr(3'd6, 8'hFF);
      put(v[15:8]);
      @(negedge clk);
      rd(3'd4, r);       chk("R2/R3/R4/R5 raw status", r, ex);
      rd(3'd5, r);       chk("R8 masked status", r, ex & en);
      chk("R9 irq_line", irq_line, ex & en);
      chk("R9 irq_any", {7'd0, irq_any}, {7'd0, |(ex & en)});
    end

    // R1: reset mid-run clears latched status
    do_reset(8'h00);
    rd(3'd4, r); chk("R1 raw cleared by reset", r, 8'h00);

    // R6: sticky edge and selective clear
    wr(3'd2, 8'h01); wr(3'd3, 8'h01);
    put(8'h01); @(negedge clk);
    rd(3'd4, r); chk("R3 rising edge sets raw", r, 8'h01);
    put(8'h00); repeat (2) @(negedge clk);
    rd(3'd4, r); chk("R6 raw sticky after line drops", r, 8'h01);
    chk("R6 irq_any held", {7'd0, irq_any}, 8'h01);
    wr(3'd6, 8'hFE);
    rd(3'd4, r); chk("R6 clear of other bits leaves raw", r, 8'h01);
    rd(3'd6, r); chk("R6 clear register reads zero", r, 8'h00);
    wr(3'd6, 8'h01);
    rd(3'd4, r); chk("R6 clear removes raw", r, 8'h00);
    chk("R6 irq_any after clear", {7'd0, irq_any}, 8'h00);

    // R7: edge and clear on the same clock edge
    @(negedge clk);
    line_in = 8'h01; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd4, r); chk("R7 edge wins over clear", r, 8'h01);

    // R5: level mode on line 1
    wr(3'd6, 8'hFF);
    wr(3'd0, 8'h02); wr(3'd2, 8'h03); wr(3'd3, 8'h02);
    put(8'h03); #1;
    rd(3'd4, r); chk("R5 level high sets raw", r, 8'h02);
    wr(3'd6, 8'h02);
    rd(3'd4, r); chk("R5 clear has no lasting effect", r, 8'h02);
    put(8'h01); #1;
    rd(3'd4, r); chk("R5 level raw follows line", r, 8'h00);

    // R8: raw visible with enable off
    put(8'h03);
    wr(3'd3, 8'h00);
    rd(3'd4, r); chk("R8 raw regardless of enable", r, 8'h02);
    rd(3'd5, r); chk("R8 masked zero when disabled", r, 8'h00);
    chk("R9 irq_line zero when disabled", irq_line, 8'h00);
    chk("R9 irq_any zero when disabled", {7'd0, irq_any}, 8'h00);

    // R11: stale status after config change removed by one clear
    do_reset(8'h00);
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
    put(8'hFF); @(negedge clk);
    rd(3'd4, r); chk("R4 both-edge latch before config change", r, 8'hFF);
    wr(3'd1, 8'h0F); wr(3'd2, 8'h33);
    repeat (3) @(negedge clk);
    wr(3'd6, 8'hFF);
    rd(3'd4, r); chk("R11 raw zero after clear", r, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd4, r); chk("R11 raw stays zero with stable lines", r, 8'h00);
    chk("R11 irq_any stays low", {7'd0, irq_any}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule